// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, every cycle, which input virtual channel of an input-buffered virtual-channel router may cross the crossbar, and on which output port. There are `P` input ports, `P` output ports and `V` virtual channels per input. Each input VC raises a request, names the output port it wants and marks whether the request is speculative. A request is speculative when it comes from a head flit whose VC allocation is being resolved in the same cycle. The parallel VC allocator returns a per-VC success bit in that cycle.

Speculative and non-speculative requests are matched by two separate two-stage allocators that run side by side. Each stage is built from round-robin arbiters: one arbiter per input picks a VC, then one arbiter per output picks an input. At every output the non-speculative result wins. A speculative win is dropped in three cases: the same output already has a non-speculative grant, the same input already holds a non-speculative grant, or the VC allocation for that flit failed. A dropped win leaves its switch slot unused for that cycle. The final matching is registered for the switch traversal stage.

The block applies no back-pressure of its own. A registered grant is the only acceptance signal a requester sees. A requester that is not granted must keep its request asserted, and it competes again in the next cycle. Grants are one-cycle pulses.

Top module: `ssa_switch_alloc`

## Requirements
- R1: Each output grants at most one input. The slice `out_sel[o*P +: P]` is one-hot or zero, and bit `i` of that slice selects input `i`.
- R2: Each input is selected by at most one output. `in_gnt[i]` is high exactly when some output selects input `i`.
- R3: A grant goes only to a VC that had a valid request, and the request's port field must equal the granting output. VC `k = input*V + vc` takes its port from `req_port[k*PW +: PW]`. A port value of `P` or more is never granted.
- R4: At each output, the winner of the non-speculative allocator takes the output. The speculative winner is used only when the non-speculative allocator gave that output nothing.
- R5: A speculative request (`req_spec` = 1) is granted only if its `va_ok` bit is high in the same cycle. Otherwise its win is dropped and that output stays idle for the cycle.
- R6: A non-speculative request (`req_spec` = 0) is granted whatever the value of its `va_ok` bit.
- R7: Each input-stage arbiter rotates over that input's VCs. It moves its priority past its winner only when that winner's grant is issued. A winner that was dropped or overridden keeps first priority in the next cycle.
- R8: Each output-stage arbiter rotates over the inputs, under the same advance-on-issue rule as R7.
- R9: Outputs are registered and reflect the requests of the previous cycle. All outputs are zero during and right after reset. `in_vc[i*VW +: VW]` holds the granted VC index, and zero when input `i` is not granted.
- R10: When an input wins a non-speculative grant, any speculative win of that same input is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | P*V | Per-VC request valid |
| req_spec | input | P*V | Per-VC speculative flag |
| req_port | input | P*V*PW | Per-VC requested output port |
| va_ok | input | P*V | Per-VC same-cycle VC allocation success |
| out_sel | output | P*P | Per-output one-hot input select, registered |
| in_gnt | output | P | Per-input grant, registered |
| in_vc | output | P*VW | Per-input granted VC index, registered |

## Verification
Directed cases come first. They show that a non-speculative request ignores `va_ok`, that a speculative request without a VC is dropped, and that non-speculative priority works both at an output and inside one input. Held request pairs show that the rotation at each stage moves only on issued grants. Long generated sweeps follow, in four phases: only non-speculative requests, only speculative requests with random VC success, a dense mix, and sparse traffic. These phases separate the plain matching from the merge and cancellation paths, and every registered output is compared against an arithmetic model of both arbiter stages.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssa_rr_arb.sv
module ssa_rr_arb #(
  parameter  int unsigned N  = 4,
  localparam int unsigned IW = ssa_pkg::idx_w(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          hit;

  // Scan from the pointer upward, wrapping, and take the first requester.
  always_comb begin
    int c;
    gnt = '0;
    win = '0;
    hit = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      c = int'(ptr) + k;
      if (c >= int'(N)) c = c - int'(N);
      if (!hit && req[c]) begin
        hit    = 1'b1;
        gnt[c] = 1'b1;
        win    = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv && hit) begin
      ptr <= (win == IW'(N-1)) ? '0 : win + 1'b1;
    end
  end
endmodule

// File: rtl/ssa_sep_alloc.sv
module ssa_sep_alloc #(
  parameter  int unsigned P  = 5,
  parameter  int unsigned V  = 4,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P*V-1:0]  vld,
  input  logic [P*V*PW-1:0] port,
  input  logic [P-1:0]    in_adv,
  input  logic [P-1:0]    out_adv,
  output logic [P*VW-1:0] s1_vc,
  output logic [P*P-1:0]  sel
);
  logic [P-1:0]  s1_any;
  logic [PW-1:0] s1_port [P];

  // Input stage: one V:1 arbiter per input port.
  for (genvar i = 0; i < P; i++) begin : g_in
    logic [V-1:0]  s1_gnt;
    logic [VW-1:0] vc_i;

    ssa_rr_arb #(.N(V)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (vld[i*V +: V]),
      .adv  (in_adv[i]),
      .gnt  (s1_gnt)
    );

    always_comb begin
      vc_i = '0;
      for (int v = 0; v < int'(V); v++) begin
        if (s1_gnt[v]) vc_i = VW'(v);
      end
    end

    assign s1_vc[i*VW +: VW] = vc_i;
    assign s1_any[i]         = |s1_gnt;
    assign s1_port[i]        = port[(i*V + int'(vc_i))*PW +: PW];
  end

  // Output stage: one P:1 arbiter per output port.
  for (genvar o = 0; o < P; o++) begin : g_out
    logic [P-1:0] s2_req;

    always_comb begin
      for (int i = 0; i < int'(P); i++) begin
        s2_req[i] = s1_any[i] && (s1_port[i] == PW'(o));
      end
    end

    ssa_rr_arb #(.N(P)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (s2_req),
      .adv  (out_adv[o]),
      .gnt  (sel[o*P +: P])
    );
  end
endmodule

// File: rtl/ssa_merge.sv
module ssa_merge #(
  parameter  int unsigned P  = 5,
  parameter  int unsigned V  = 4,
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input  logic [P*P-1:0]  ns_sel,
  input  logic [P*P-1:0]  sp_sel,
  input  logic [P*VW-1:0] ns_vc,
  input  logic [P*VW-1:0] sp_vc,
  input  logic [P*V-1:0]  va_ok,
  output logic [P*P-1:0]  fin_sel,
  output logic [P-1:0]    fin_gnt,
  output logic [P*VW-1:0] fin_vc,
  output logic [P-1:0]    ns_in_adv,
  output logic [P-1:0]    ns_out_adv,
  output logic [P-1:0]    sp_in_adv,
  output logic [P-1:0]    sp_out_adv
);
  logic [P-1:0] ns_busy;
  logic [P-1:0] ns_hit;
  logic [P-1:0] sp_va;
  logic [P-1:0] sp_keep;

  always_comb begin
    logic keep;
    ns_busy    = '0;
    ns_hit     = '0;
    sp_va      = '0;
    sp_keep    = '0;
    sp_out_adv = '0;
    fin_sel    = '0;
    for (int o = 0; o < int'(P); o++) begin
      ns_busy[o] = |ns_sel[o*P +: P];
      for (int i = 0; i < int'(P); i++) begin
        if (ns_sel[o*P + i]) ns_hit[i] = 1'b1;
      end
    end
    for (int i = 0; i < int'(P); i++) begin
      sp_va[i] = va_ok[i*V + int'(sp_vc[i*VW +: VW])];
    end
    // A speculative win survives only on a free output, a free input and a held VC.
    for (int o = 0; o < int'(P); o++) begin
      for (int i = 0; i < int'(P); i++) begin
        keep = sp_sel[o*P + i] && !ns_busy[o] && !ns_hit[i] && sp_va[i];
        fin_sel[o*P + i] = ns_sel[o*P + i] | keep;
        if (keep) begin
          sp_keep[i]    = 1'b1;
          sp_out_adv[o] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < int'(P); i++) begin
      fin_vc[i*VW +: VW] = ns_hit[i]  ? ns_vc[i*VW +: VW] :
                           sp_keep[i] ? sp_vc[i*VW +: VW] : '0;
    end
  end

  assign fin_gnt    = ns_hit | sp_keep;
  assign ns_in_adv  = ns_hit;
  assign ns_out_adv = ns_busy;
  assign sp_in_adv  = sp_keep;
endmodule

// File: rtl/ssa_switch_alloc.sv
module ssa_switch_alloc #(
  parameter  int unsigned P  = 5,
  parameter  int unsigned V  = 4,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P*V-1:0]    req_vld,
  input  logic [P*V-1:0]    req_spec,
  input  logic [P*V*PW-1:0] req_port,
  input  logic [P*V-1:0]    va_ok,
  output logic [P*P-1:0]    out_sel,
  output logic [P-1:0]      in_gnt,
  output logic [P*VW-1:0]   in_vc
);
  logic [P*V-1:0]  ns_vld, sp_vld;
  logic [P*P-1:0]  ns_sel, sp_sel, fin_sel;
  logic [P*VW-1:0] ns_vc, sp_vc, fin_vc;
  logic [P-1:0]    fin_gnt;
  logic [P-1:0]    ns_in_adv, ns_out_adv, sp_in_adv, sp_out_adv;

  assign ns_vld = req_vld & ~req_spec;
  assign sp_vld = req_vld &  req_spec;

  ssa_sep_alloc #(.P(P), .V(V)) u_ns (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (ns_vld),
    .port   (req_port),
    .in_adv (ns_in_adv),
    .out_adv(ns_out_adv),
    .s1_vc  (ns_vc),
    .sel    (ns_sel)
  );

  ssa_sep_alloc #(.P(P), .V(V)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (sp_vld),
    .port   (req_port),
    .in_adv (sp_in_adv),
    .out_adv(sp_out_adv),
    .s1_vc  (sp_vc),
    .sel    (sp_sel)
  );

  ssa_merge #(.P(P), .V(V)) u_merge (
    .ns_sel    (ns_sel),
    .sp_sel    (sp_sel),
    .ns_vc     (ns_vc),
    .sp_vc     (sp_vc),
    .va_ok     (va_ok),
    .fin_sel   (fin_sel),
    .fin_gnt   (fin_gnt),
    .fin_vc    (fin_vc),
    .ns_in_adv (ns_in_adv),
    .ns_out_adv(ns_out_adv),
    .sp_in_adv (sp_in_adv),
    .sp_out_adv(sp_out_adv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sel <= '0;
      in_gnt  <= '0;
      in_vc   <= '0;
    end else begin
      out_sel <= fin_sel;
      in_gnt  <= fin_gnt;
      in_vc   <= fin_vc;
    end
  end
endmodule

// File: rtl/ssa_switch_alloc_chk.sv
module ssa_switch_alloc_chk #(
  parameter  int unsigned P  = 5,
  parameter  int unsigned V  = 4,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [P*V-1:0]    req_vld,
  input logic [P*V-1:0]    req_spec,
  input logic [P*V*PW-1:0] req_port,
  input logic [P*V-1:0]    va_ok,
  input logic [P*P-1:0]    out_sel,
  input logic [P-1:0]      in_gnt,
  input logic [P*VW-1:0]   in_vc
);
  logic [P*V-1:0]    prv_vld, prv_spec, prv_va;
  logic [P*V*PW-1:0] prv_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_vld  <= '0;
      prv_spec <= '0;
      prv_va   <= '0;
      prv_port <= '0;
    end else begin
      prv_vld  <= req_vld;
      prv_spec <= req_spec;
      prv_va   <= va_ok;
      prv_port <= req_port;
    end
  end

  logic [P-1:0]  g_vld, g_spec, g_va;
  logic [PW-1:0] g_port [P];
  logic [P-1:0]  col [P];

  always_comb begin
    int k;
    for (int i = 0; i < int'(P); i++) begin
      k         = i*int'(V) + int'(in_vc[i*VW +: VW]);
      g_vld[i]  = prv_vld[k];
      g_spec[i] = prv_spec[k];
      g_va[i]   = prv_va[k];
      g_port[i] = prv_port[k*PW +: PW];
      for (int o = 0; o < int'(P); o++) col[i][o] = out_sel[o*P + i];
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_o
    a_r1_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_sel[o*P +: P]));
    for (genvar i = 0; i < P; i++) begin : g_i
      a_r3_port_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel[o*P + i] |-> (g_port[i] == PW'(o)));
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_in
    a_r2_in_once: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[i]));
    a_r2_gnt_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_gnt[i] == (|col[i]));
    a_r3_valid_req: assert property (@(posedge clk) disable iff (!rst_n)
      in_gnt[i] |-> g_vld[i]);
    a_r5_vc_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_gnt[i] && g_spec[i]) |-> g_va[i]);
  end

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (prv_vld == '0) |-> (in_gnt == '0 && out_sel == '0));
endmodule

bind ssa_switch_alloc ssa_switch_alloc_chk #(.P(P), .V(V)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_vld (req_vld),
  .req_spec(req_spec),
  .req_port(req_port),
  .va_ok   (va_ok),
  .out_sel (out_sel),
  .in_gnt  (in_gnt),
  .in_vc   (in_vc)
);

// File: tb/ssa_switch_alloc_tb_top.sv
`timescale 1ns/1ps
module ssa_switch_alloc_tb_top;
  localparam int P  = 3;
  localparam int V  = 2;
  localparam int PW = 2;
  localparam int VW = 1;
  localparam int N  = P*V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_vld = '0, req_spec = '0, va_ok = '0;
  logic [N*PW-1:0] req_port = '0;
  logic [P*P-1:0]  out_sel;
  logic [P-1:0]    in_gnt;
  logic [P*VW-1:0] in_vc;

  always #4 clk = ~clk;

  ssa_switch_alloc #(.P(P), .V(V)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_spec(req_spec),
    .req_port(req_port), .va_ok(va_ok), .out_sel(out_sel),
    .in_gnt(in_gnt), .in_vc(in_vc)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // stimulus and model state
  bit t_vld[N], t_spec[N], t_va[N];
  int t_port[N];
  int nsp1[P], nsp2[P], ssp1[P], ssp2[P];
  int e_sel[P], e_vc[P];
  bit e_g[P];
  bit q_spec[N], q_va[N];
  int unsigned lfsr = 32'h1234_5678;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int pick(input bit m[8], input int ptr, input int n);
    for (int k = 0; k < n; k++) begin
      if (m[(ptr + k) % n]) return (ptr + k) % n;
    end
    return -1;
  endfunction

  task automatic model();
    int s1n[P], s1s[P], on[P], os[P];
    bit m[8];
    bit nh[P];
    for (int i = 0; i < P; i++) begin
      for (int v = 0; v < 8; v++) m[v] = (v < V) && t_vld[i*V+v] && !t_spec[i*V+v];
      s1n[i] = pick(m, nsp1[i], V);
      for (int v = 0; v < 8; v++) m[v] = (v < V) && t_vld[i*V+v] && t_spec[i*V+v];
      s1s[i] = pick(m, ssp1[i], V);
    end
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < 8; i++) m[i] = (i < P) && s1n[i] >= 0 && t_port[i*V+s1n[i]] == o;
      on[o] = pick(m, nsp2[o], P);
      for (int i = 0; i < 8; i++) m[i] = (i < P) && s1s[i] >= 0 && t_port[i*V+s1s[i]] == o;
      os[o] = pick(m, ssp2[o], P);
    end
    for (int i = 0; i < P; i++) begin nh[i] = 0; e_g[i] = 0; e_vc[i] = 0; end
    for (int o = 0; o < P; o++) if (on[o] >= 0) nh[on[o]] = 1;
    for (int o = 0; o < P; o++) begin
      e_sel[o] = -1;
      if (on[o] >= 0) begin
        e_sel[o] = on[o]; e_g[on[o]] = 1; e_vc[on[o]] = s1n[on[o]];
        nsp1[on[o]] = (s1n[on[o]] + 1) % V;
        nsp2[o] = (on[o] + 1) % P;
      end else if (os[o] >= 0 && !nh[os[o]] && t_va[os[o]*V + s1s[os[o]]]) begin
        e_sel[o] = os[o]; e_g[os[o]] = 1; e_vc[os[o]] = s1s[os[o]];
        ssp1[os[o]] = (s1s[os[o]] + 1) % V;
        ssp2[o] = (os[o] + 1) % P;
      end
    end
  endtask

  task automatic clr();
    for (int k = 0; k < N; k++) begin t_vld[k] = 0; t_spec[k] = 0; t_va[k] = 0; t_port[k] = 0; end
  endtask

  task automatic rq(input int i, input int v, input int port, input bit spec, input bit va);
    t_vld[i*V+v] = 1; t_port[i*V+v] = port; t_spec[i*V+v] = spec; t_va[i*V+v] = va;
  endtask

  // Drive, step one clock, then compare everything at the following negedge.
  task automatic step();
    for (int k = 0; k < N; k++) begin
      req_vld[k] = t_vld[k]; req_spec[k] = t_spec[k]; va_ok[k] = t_va[k];
      req_port[k*PW +: PW] = PW'(t_port[k]);
      q_spec[k] = t_spec[k]; q_va[k] = t_va[k];
    end
    model();
    @(posedge clk);
    @(negedge clk);
    for (int o = 0; o < P; o++) begin
      int exp_bits = (e_sel[o] >= 0) ? (1 << e_sel[o]) : 0;
      chk($countones(out_sel[o*P +: P]) <= 1, "R1", $countones(out_sel[o*P +: P]), 1);
      chk(int'(out_sel[o*P +: P]) == exp_bits, "R4/R8 out_sel", int'(out_sel[o*P +: P]), exp_bits);
    end
    for (int i = 0; i < P; i++) begin
      int cnt = 0;
      for (int o = 0; o < P; o++) cnt += out_sel[o*P+i];
      chk(cnt <= 1 && (in_gnt[i] == (cnt == 1)), "R2", cnt, int'(in_gnt[i]));
      chk(in_gnt[i] == e_g[i], "R7/R10 in_gnt", int'(in_gnt[i]), int'(e_g[i]));
      chk(int'(in_vc[i*VW +: VW]) == e_vc[i], "R9 in_vc", int'(in_vc[i*VW +: VW]), e_vc[i]);
      if (in_gnt[i]) begin
        int k = i*V + int'(in_vc[i*VW +: VW]);
        chk(!q_spec[k] || q_va[k], "R5", int'(q_va[k]), 1);
      end
    end
  endtask

  function automatic int unsigned rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  initial begin
    for (int i = 0; i < P; i++) begin nsp1[i] = 0; nsp2[i] = 0; ssp1[i] = 0; ssp2[i] = 0; end
    clr();
    repeat (3) @(negedge clk);
    chk(out_sel == '0 && in_gnt == '0 && in_vc == '0, "R9 reset", int'(in_gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_sel == '0 && in_gnt == '0, "R9 after reset", int'(out_sel), 0);

    // R6: non-speculative request granted even with va_ok low
    clr(); rq(0, 0, 2, 0, 0);
    for (int k = 0; k < N; k++) begin
      req_vld[k] = t_vld[k]; req_spec[k] = t_spec[k]; va_ok[k] = t_va[k];
      req_port[k*PW +: PW] = PW'(t_port[k]);
    end
    #1 chk(in_gnt == '0, "R9 latency", int'(in_gnt), 0);
    step();
    chk(out_sel[6 +: 3] == 3'b001 && in_vc[0] == 1'b0, "R6", int'(out_sel[6 +: 3]), 1);

    // R5: speculative request without a VC is dropped, then granted once VC held
    clr(); rq(1, 1, 0, 1, 0); step();
    chk(in_gnt == '0 && out_sel == '0, "R5 cancel", int'(out_sel), 0);
    clr(); rq(1, 1, 0, 1, 1); step();
    chk(out_sel[0 +: 3] == 3'b010 && in_vc[1] == 1'b1, "R5 granted", int'(out_sel[0 +: 3]), 2);

    // R4 at output 1; R10 inside input 1
    clr(); rq(0, 0, 1, 0, 0); rq(2, 0, 1, 1, 1); rq(1, 0, 0, 0, 0); rq(1, 1, 2, 1, 1); step();
    chk(out_sel[3 +: 3] == 3'b001 && !in_gnt[2], "R4", int'(out_sel[3 +: 3]), 1);
    chk(out_sel[0 +: 3] == 3'b010 && out_sel[6 +: 3] == 3'b000, "R10", int'(out_sel[6 +: 3]), 0);

    // R7: two VCs of input 0 alternate (pointer now at VC1)
    clr(); rq(0, 0, 0, 0, 0); rq(0, 1, 0, 0, 0); step();
    chk(in_vc[0] == 1'b1, "R7 first", int'(in_vc[0]), 1);
    step();
    chk(in_vc[0] == 1'b0, "R7 second", int'(in_vc[0]), 0);

    // R7: dropped speculative winner keeps priority
    clr(); rq(2, 0, 2, 1, 0); rq(2, 1, 2, 1, 1); step();
    chk(!in_gnt[2], "R7 hold a", int'(in_gnt[2]), 0);
    step();
    chk(!in_gnt[2], "R7 hold b", int'(in_gnt[2]), 0);
    clr(); rq(2, 0, 2, 1, 1); rq(2, 1, 2, 1, 1); step();
    chk(in_gnt[2] && in_vc[2] == 1'b0, "R7 release", int'(in_vc[2]), 0);

    // R8: inputs 0 and 1 alternate at output 0 (pointer now at input 1)
    clr(); rq(0, 0, 0, 0, 0); rq(1, 0, 0, 0, 0); step();
    chk(out_sel[0 +: 3] == 3'b010, "R8 first", int'(out_sel[0 +: 3]), 2);
    step();
    chk(out_sel[0 +: 3] == 3'b001, "R8 second", int'(out_sel[0 +: 3]), 1);
    step();
    chk(out_sel[0 +: 3] == 3'b010, "R8 third", int'(out_sel[0 +: 3]), 2);

    // R3 port out of range never granted
    clr(); rq(1, 0, 3, 0, 1); step();
    chk(in_gnt == '0, "R3 bad port", int'(in_gnt), 0);

    // Sweeps: non-spec only, spec only, dense mix, sparse mix
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        clr();
        for (int k = 0; k < N; k++) begin
          int unsigned r = rnd();
          t_vld[k]  = (ph == 3) ? (r[3:0] == 0) : (r[1:0] != 0);
          t_spec[k] = (ph == 0) ? 0 : (ph == 1) ? 1 : r[4];
          t_va[k]   = r[5];
          t_port[k] = int'(r[15:8]) % P;
        end
        step();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule